// File: doc/BRIEF.md
# Lane-Mask Sequencer for Divergent Branches

This block drives eight processing lanes from one shared instruction stream. Every cycle it reads one word from a program ROM and issues that word to all lanes together with an active mask. Each lane supplies its own branch condition. When the active lanes disagree on an if/else, the block runs the taken side first, using only the lanes whose condition was true. It then runs the other side with the remaining lanes, and after that it restores the full mask and continues at the shared code that follows. A divergent branch therefore costs the length of both sides.

Nested branches and data-dependent loops keep their masks on a small reconvergence stack. A loop keeps issuing its body until the last lane leaves. A lane that has left stays masked off until the loop ends. If the lanes all agree on a branch, the side that no lane needs is skipped without being issued. Two counters are exported so that the serialization penalty can be measured: one counts issued instructions and one sums the active lanes over those instructions. A push onto a full stack sets a sticky error flag.

Instruction word, 16 bits: bits [15:12] hold the opcode and bits [11:0] hold a target address. The opcodes are 0 plain, 1 branch-if, 2 else-marker, 3 join, 4 loop-open, 5 loop-close, 15 stop. Any other opcode is treated as plain.

Top module: `simt_div_ctrl`

## Requirements
- R1: After reset, `issue_valid`, `done`, `stack_err`, `cycle_count` and `util_count` are 0, and `prog_addr` is 0.
- R2: After a `start` pulse the block fetches from address 0 and issues one ROM word per cycle with no gaps. The issued word equals the ROM word at the fetched address, and straight-line code is issued with mask 0xFF.
- R3: At a branch-if (opcode 1) under mask M with conditions C, where M&C and M&~C are both nonzero, the block issues the then-side with mask M&C. The else-marker (opcode 2) is issued with mask M&C, and the else-side, which starts right after the marker, is issued with mask M&~C. The join (opcode 3) is issued with mask M&~C, and the code after the join is issued with mask M again.
- R4: If M&~C is 0, the then-side runs with mask M. The else-marker then jumps to its target (the join) and no else-side word is issued.
- R5: If M&C is 0, the branch-if jumps to its target (the first else-side word) and no then-side word is issued.
- R6: Nested branches narrow the mask further. An inner join restores the outer side's mask, and the outer else-side still runs afterwards.
- R7: A loop-open (opcode 4) saves the mask. At a loop-close (opcode 5) with target T, if M&C is nonzero the block jumps to T with mask M&C. Otherwise it restores the saved mask and continues at the next address. Lanes that have left stay masked off while the loop continues.
- R8: The stack holds 4 entries. A fifth nested push sets `stack_err`, which stays set until reset. Four nested pushes leave it clear.
- R9: `cycle_count` equals the number of issued words since `start`, and `util_count` equals the sum of the set bits in the issued masks.
- R10: Stop (opcode 15) is not issued. It raises `done`, after which `issue_valid` stays 0 and `prog_addr` and both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: restart at address 0 with all lanes active |
| prog_addr | output | 12 | Program ROM read address (the current PC) |
| prog_data | input | 16 | ROM word at `prog_addr`, same cycle |
| lane_cond | input | 8 | Per-lane condition for the word at `prog_addr` |
| issue_valid | output | 1 | A word is being issued this cycle |
| issue_instr | output | 16 | Issued instruction word |
| issue_mask | output | 8 | Active lanes for the issued word |
| done | output | 1 | Program reached stop |
| stack_err | output | 1 | Sticky stack overflow flag |
| cycle_count | output | 16 | Issued word count |
| util_count | output | 20 | Sum of active lanes over issued words |

## Verification
The bound checker checks these properties on every cycle:
- An issued mask is never empty.
- The word issued right after a branch-if carries a mask that is a subset of the branch's mask.
- Nothing is issued while `done` is high.
- The issue counter steps by exactly one for each issued word.
- The overflow flag never clears on its own.

Whether a divergent branch runs both sides in the right order with complementary masks, whether a uniform branch really skips the unused side, and how a loop's mask shrinks pass by pass can only be shown by the directed programs. Each of those programs compares the full issued trace with a trace worked out by hand.

// File: rtl/simt_pkg.sv
package simt_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_PLAIN   = 4'h0,
    OP_BRIF    = 4'h1,
    OP_ELSE    = 4'h2,
    OP_JOIN    = 4'h3,
    OP_LOPEN   = 4'h4,
    OP_LCLOSE  = 4'h5,
    OP_STOP    = 4'hF
  } op_e;
endpackage

// File: rtl/simt_branch_eval.sv
// Splits the current mask by the lanes' conditions.
module simt_branch_eval #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] took_mask,
  output logic [LANES-1:0] rest_mask,
  output logic             any_took,
  output logic             any_rest
);
  assign took_mask = cur_mask & cond;
  assign rest_mask = cur_mask & ~cond;
  assign any_took  = |took_mask;
  assign any_rest  = |rest_mask;
endmodule

// File: rtl/simt_popcount.sv
module simt_popcount #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/simt_recon_stack.sv
// Reconvergence stack: each entry keeps the mask to restore and the
// mask still waiting for its else-side (zero once consumed).
module simt_recon_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_restore,
  input  logic [W-1:0] push_pending,
  input  logic         pop,
  input  logic         take_pending,
  output logic [W-1:0] top_restore,
  output logic [W-1:0] top_pending,
  output logic         empty,
  output logic         overflow
);
  logic [W-1:0]     restore_q [DEPTH];
  logic [W-1:0]     pending_q [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] top_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             full;

  assign full     = (sp == SP_W'(DEPTH));
  assign empty    = (sp == '0);
  assign top_idx  = IDX_W'(sp - SP_W'(1));
  assign wr_idx   = IDX_W'(sp);
  assign overflow = push && full;

  assign top_restore = empty ? '0 : restore_q[top_idx];
  assign top_pending = empty ? '0 : pending_q[top_idx];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sp <= '0;
    end else if (push) begin
      if (!full) begin
        restore_q[wr_idx] <= push_restore;
        pending_q[wr_idx] <= push_pending;
        sp <= sp + SP_W'(1);
      end
    end else if (pop) begin
      if (!empty) sp <= sp - SP_W'(1);
    end else if (take_pending && !empty) begin
      pending_q[top_idx] <= '0;
    end
  end
endmodule

// File: rtl/simt_div_ctrl.sv
module simt_div_ctrl
  import simt_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int INSTR_W   = 16,
  parameter int CNT_W     = 16,
  parameter int STK_DEPTH = 4,
  localparam int PC_W    = INSTR_W - OPC_W,
  localparam int LCNT_W  = $clog2(LANES + 1),
  localparam int UTIL_W  = CNT_W + LCNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic [PC_W-1:0]    prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic [LANES-1:0]   lane_cond,
  output logic               issue_valid,
  output logic [INSTR_W-1:0] issue_instr,
  output logic [LANES-1:0]   issue_mask,
  output logic               done,
  output logic               stack_err,
  output logic [CNT_W-1:0]   cycle_count,
  output logic [UTIL_W-1:0]  util_count
);
  logic [PC_W-1:0]   pc, pc_n;
  logic [LANES-1:0]  mask, mask_n;
  logic              running;
  op_e               op;
  logic [PC_W-1:0]   tgt;

  logic [LANES-1:0]  took_mask, rest_mask;
  logic              any_took, any_rest;
  logic [LCNT_W-1:0] lanes_on;

  logic              do_push, do_pop, do_take, stop_now, step;
  logic [LANES-1:0]  push_pend;
  logic [LANES-1:0]  top_restore, top_pending;
  logic              stk_empty, stk_ovf;

  assign op        = op_e'(prog_data[INSTR_W-1 -: OPC_W]);
  assign tgt       = prog_data[PC_W-1:0];
  assign prog_addr = pc;
  assign step      = running && !start;

  simt_branch_eval #(.LANES(LANES)) u_eval (
    .cur_mask (mask),
    .cond     (lane_cond),
    .took_mask(took_mask),
    .rest_mask(rest_mask),
    .any_took (any_took),
    .any_rest (any_rest)
  );

  simt_popcount #(.W(LANES)) u_pop (
    .bits (mask),
    .count(lanes_on)
  );

  simt_recon_stack #(.W(LANES), .DEPTH(STK_DEPTH)) u_stack (
    .clk         (clk),
    .rst         (rst),
    .clr         (start),
    .push        (do_push && step),
    .push_restore(mask),
    .push_pending(push_pend),
    .pop         (do_pop && step),
    .take_pending(do_take && step),
    .top_restore (top_restore),
    .top_pending (top_pending),
    .empty       (stk_empty),
    .overflow    (stk_ovf)
  );

  // Next PC, next mask and stack action for the word at pc
  always_comb begin
    pc_n      = pc + PC_W'(1);
    mask_n    = mask;
    do_push   = 1'b0;
    do_pop    = 1'b0;
    do_take   = 1'b0;
    stop_now  = 1'b0;
    push_pend = '0;
    case (op)
      OP_BRIF: begin
        do_push = 1'b1;
        if (any_took) begin
          mask_n    = took_mask;
          push_pend = rest_mask;   // zero when every lane took it
        end else begin
          pc_n = tgt;              // no lane takes the then-side
        end
      end
      OP_ELSE: begin
        if (!stk_empty && (top_pending != '0)) begin
          mask_n  = top_pending;
          do_take = 1'b1;
        end else begin
          pc_n = tgt;              // nothing waiting: go to the join
        end
      end
      OP_JOIN: begin
        do_pop = 1'b1;
        if (!stk_empty) mask_n = top_restore;
      end
      OP_LOPEN: begin
        do_push = 1'b1;
      end
      OP_LCLOSE: begin
        if (any_took) begin
          mask_n = took_mask;
          pc_n   = tgt;
        end else begin
          do_pop = 1'b1;
          if (!stk_empty) mask_n = top_restore;
        end
      end
      OP_STOP: begin
        stop_now = 1'b1;
        pc_n     = pc;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      mask        <= '1;
      running     <= 1'b0;
      done        <= 1'b0;
      stack_err   <= 1'b0;
      issue_valid <= 1'b0;
      issue_instr <= '0;
      issue_mask  <= '0;
      cycle_count <= '0;
      util_count  <= '0;
    end else if (start) begin
      pc          <= '0;
      mask        <= '1;
      running     <= 1'b1;
      done        <= 1'b0;
      issue_valid <= 1'b0;
      cycle_count <= '0;
      util_count  <= '0;
    end else if (running) begin
      if (stk_ovf) stack_err <= 1'b1;
      if (stop_now) begin
        running     <= 1'b0;
        done        <= 1'b1;
        issue_valid <= 1'b0;
      end else begin
        pc          <= pc_n;
        mask        <= mask_n;
        issue_valid <= 1'b1;
        issue_instr <= prog_data;
        issue_mask  <= mask;
        cycle_count <= cycle_count + CNT_W'(1);
        util_count  <= util_count + UTIL_W'(lanes_on);
      end
    end else begin
      issue_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/simt_div_chk.sv
module simt_div_chk #(
  parameter int LANES = 8,
  parameter int CNT_W = 16,
  parameter int OPC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             issue_valid,
  input logic [OPC_W-1:0] issue_op,
  input logic [LANES-1:0] issue_mask,
  input logic             done,
  input logic             stack_err,
  input logic [CNT_W-1:0] cycle_count
);
  // R3: an issued word always has at least one live lane
  p_mask_live_r3: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (issue_mask != '0));

  // R6: the word after a branch-if never widens the mask
  p_branch_narrows_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op == OPC_W'(1)) |=>
      (!issue_valid || ((issue_mask & ~$past(issue_mask)) == '0)));

  // R10: nothing issues once stopped
  p_quiet_when_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !issue_valid);

  // R9: counter advances exactly with issued words
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    !start |=> (cycle_count == $past(cycle_count) + CNT_W'(issue_valid)));

  // R8: overflow flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    stack_err |=> stack_err);
endmodule

bind simt_div_ctrl simt_div_chk #(
  .LANES(LANES), .CNT_W(CNT_W), .OPC_W(simt_pkg::OPC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .issue_valid(issue_valid),
  .issue_op   (issue_instr[INSTR_W-1 -: simt_pkg::OPC_W]),
  .issue_mask (issue_mask),
  .done       (done),
  .stack_err  (stack_err),
  .cycle_count(cycle_count)
);

// File: tb/tb_simt_div_ctrl.sv
`timescale 1ns/1ps
module tb_simt_div_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [11:0] prog_addr;
  logic [15:0] prog_data;
  logic [7:0]  lane_cond;
  logic        issue_valid, done, stack_err;
  logic [15:0] issue_instr;
  logic [7:0]  issue_mask;
  logic [15:0] cycle_count;
  logic [19:0] util_count;

  always #10 clk = ~clk;   // 50 MHz

  simt_div_ctrl dut (
    .clk(clk), .rst(rst), .start(start), .prog_addr(prog_addr),
    .prog_data(prog_data), .lane_cond(lane_cond),
    .issue_valid(issue_valid), .issue_instr(issue_instr),
    .issue_mask(issue_mask), .done(done), .stack_err(stack_err),
    .cycle_count(cycle_count), .util_count(util_count)
  );

  logic [15:0] rom [16];
  logic [7:0]  cond_tab [16];
  int          lim [8];
  int          loop_k;

  assign prog_data = rom[prog_addr[3:0]];

  // Per-lane conditions: loop-close uses iteration limits, others a table
  always_comb begin
    if (rom[prog_addr[3:0]][15:12] == 4'h5) begin
      for (int i = 0; i < 8; i++) lane_cond[i] = (loop_k + 1 < lim[i]);
    end else begin
      lane_cond = cond_tab[prog_addr[3:0]];
    end
  end

  always @(posedge clk) begin
    if (rst) loop_k <= 0;
    else if (rom[prog_addr[3:0]][15:12] == 4'h5) loop_k <= loop_k + 1;
  end

  int n_vec = 0, n_bad = 0;
  logic [15:0] got_i [64];
  logic [7:0]  got_m [64];
  int          got_n, first_cyc, last_cyc;
  logic [15:0] exp_i [64];
  logic [7:0]  exp_m [64];
  int          exp_n;

  function automatic logic [15:0] w(input logic [3:0] op, input int t);
    return {op, 12'(t)};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) begin rom[i] = w(4'hF, 0); cond_tab[i] = 8'h00; end
    for (int i = 0; i < 8; i++) lim[i] = 1;
    exp_n = 0;
  endtask

  task automatic put(input logic [15:0] ins, input logic [7:0] m);
    exp_i[exp_n] = ins; exp_m[exp_n] = m; exp_n++;
  endtask

  task automatic run_prog(input string req);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!issue_valid && !done && !stack_err && cycle_count == 0 && util_count == 0 && prog_addr == 0,
        "R1 reset state", {issue_valid, done, stack_err, prog_addr}, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    got_n = 0; first_cyc = -1; last_cyc = -1;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (issue_valid && got_n < 64) begin
        if (first_cyc < 0) first_cyc = c;
        last_cyc = c;
        got_i[got_n] = issue_instr; got_m[got_n] = issue_mask; got_n++;
      end
      if (done) break;
    end
    chk(done == 1'b1, {req, " reached stop"}, done, 1);
  endtask

  task automatic cmp_trace(input string req);
    chk(got_n == exp_n, {req, " issued length"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_i[i] == exp_i[i], {req, " issued word"}, got_i[i], exp_i[i]);
      chk(got_m[i] == exp_m[i], {req, " issued mask"}, got_m[i], exp_m[i]);
    end
  endtask

  task automatic t_straight();
    clear_prog();
    rom[0] = w(0, 1); rom[1] = w(0, 2); rom[2] = w(0, 3); rom[3] = w(4'hF, 0);
    put(rom[0], 8'hFF); put(rom[1], 8'hFF); put(rom[2], 8'hFF);
    run_prog("R2");
    cmp_trace("R2");
    chk(last_cyc - first_cyc + 1 == got_n, "R2 no gaps", last_cyc - first_cyc + 1, got_n);
    chk(cycle_count == 3, "R9 cycle count", cycle_count, 3);
    chk(util_count == 24, "R9 util count", util_count, 24);
    // R10: hold after stop
    begin
      logic [11:0] pa; pa = prog_addr;
      repeat (3) @(negedge clk);
      chk(!issue_valid && done, "R10 quiet after stop", issue_valid, 0);
      chk(prog_addr == pa && cycle_count == 3 && util_count == 24,
          "R10 state frozen", cycle_count, 3);
    end
  endtask

  task automatic load_ifelse(input logic [7:0] c);
    clear_prog();
    rom[0] = w(0, 16'h10);
    rom[1] = w(1, 4);  cond_tab[1] = c;
    rom[2] = w(0, 16'h11);
    rom[3] = w(2, 5);
    rom[4] = w(0, 16'h12);
    rom[5] = w(3, 0);
    rom[6] = w(0, 16'h13);
    rom[7] = w(4'hF, 0);
  endtask

  task automatic t_diverge();
    load_ifelse(8'h0F);
    put(rom[0], 8'hFF); put(rom[1], 8'hFF); put(rom[2], 8'h0F); put(rom[3], 8'h0F);
    put(rom[4], 8'hF0); put(rom[5], 8'hF0); put(rom[6], 8'hFF);
    run_prog("R3");
    cmp_trace("R3");
    chk(cycle_count == 7, "R9 divergent cycles", cycle_count, 7);
    chk(util_count == 40, "R9 divergent util", util_count, 40);
  endtask

  task automatic t_all_take();
    load_ifelse(8'hFF);
    put(rom[0], 8'hFF); put(rom[1], 8'hFF); put(rom[2], 8'hFF); put(rom[3], 8'hFF);
    put(rom[5], 8'hFF); put(rom[6], 8'hFF);
    run_prog("R4");
    cmp_trace("R4");
  endtask

  task automatic t_none_take();
    load_ifelse(8'h00);
    put(rom[0], 8'hFF); put(rom[1], 8'hFF); put(rom[4], 8'hFF);
    put(rom[5], 8'hFF); put(rom[6], 8'hFF);
    run_prog("R5");
    cmp_trace("R5");
  endtask

  task automatic t_nested();
    clear_prog();
    rom[0] = w(1, 7); cond_tab[0] = 8'h0F;
    rom[1] = w(1, 4); cond_tab[1] = 8'h33;
    rom[2] = w(0, 16'h20);
    rom[3] = w(2, 5);
    rom[4] = w(0, 16'h21);
    rom[5] = w(3, 0);
    rom[6] = w(2, 8);
    rom[7] = w(0, 16'h22);
    rom[8] = w(3, 0);
    rom[9] = w(4'hF, 0);
    put(rom[0], 8'hFF); put(rom[1], 8'h0F); put(rom[2], 8'h03); put(rom[3], 8'h03);
    put(rom[4], 8'h0C); put(rom[5], 8'h0C); put(rom[6], 8'h0F); put(rom[7], 8'hF0);
    put(rom[8], 8'hF0);
    run_prog("R6");
    cmp_trace("R6");
  endtask

  task automatic t_loop();
    clear_prog();
    lim[0] = 1; lim[1] = 1; lim[2] = 2; lim[3] = 2;
    lim[4] = 3; lim[5] = 3; lim[6] = 1; lim[7] = 4;
    rom[0] = w(4, 0); rom[1] = w(0, 16'h30); rom[2] = w(5, 1);
    rom[3] = w(0, 16'h31); rom[4] = w(4'hF, 0);
    put(rom[0], 8'hFF); put(rom[1], 8'hFF); put(rom[2], 8'hFF);
    put(rom[1], 8'hBC); put(rom[2], 8'hBC);
    put(rom[1], 8'hB0); put(rom[2], 8'hB0);
    put(rom[1], 8'h80); put(rom[2], 8'h80);
    put(rom[3], 8'hFF);
    run_prog("R7");
    cmp_trace("R7");
    chk(cycle_count == 10, "R9 loop cycles", cycle_count, 10);
    chk(util_count == 50, "R9 loop util", util_count, 50);
    chk(stack_err == 1'b0, "R8 no error in shallow loop", stack_err, 0);
  endtask

  task automatic t_depth(input int n, input bit expect_err);
    clear_prog();
    for (int i = 0; i < n; i++) rom[i] = w(4, 0);
    run_prog("R8");
    repeat (2) @(negedge clk);
    chk(stack_err == expect_err, "R8 overflow flag", stack_err, expect_err);
  endtask

  initial begin
    clear_prog();
    t_straight();
    t_diverge();
    t_all_take();
    t_none_take();
    t_nested();
    t_loop();
    t_depth(4, 1'b0);
    t_depth(5, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule